// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses the direction of conditional branches at fetch time and learns from the outcomes that execution resolves later. The fetch stage presents a PC on the predict port. A taken or not-taken answer comes back combinationally in the same cycle. When a branch resolves, the back end presents its PC and its actual direction on the update port. The block then trains one table entry and shifts the outcome into a global history register.

The block has two modes. In correlating mode, the table index joins the global history of the most recent outcomes with the low word-address bits of the PC. Each entry is a 2-bit saturating counter. In last-outcome mode, the index uses the PC bits alone. Each entry then only remembers the direction of its previous execution, so the two schemes can be compared on the same code. The table carries no tag. Branches whose low PC bits match therefore share entries.

Top module: `branch_corr_pred`

## Requirements
- R1: After reset, every table entry holds 2'b01 (weakly not-taken) and the history register holds all zeros, so every PC is predicted not-taken.
- R2: `pred_taken_o` depends only on the current inputs and the stored state, within the same cycle. When an update lands in the same cycle, the prediction uses the state from before that update. With no update in the previous cycle and the same PC and mode, the prediction does not change.
- R3: In correlating mode, the entry index is {history, pc[5:2]} with the history in the upper bits. There is no address check, so PCs that differ only in bit 6 or above share an entry.
- R4: In last-outcome mode, the index is pc[5:2] with zeros in the history bits. An update writes 2'b11 when taken and 2'b00 when not-taken. The prediction is the last outcome written to that entry.
- R5: In last-outcome mode, a loop branch taken four times and then not taken mispredicts exactly twice per loop visit once the loop repeats: at the exit and at the first iteration of the next visit.
- R6: In correlating mode, an update increments the entry on taken and decrements it on not-taken, saturating at 3 and 0. The prediction is bit 1 of the entry, so one not-taken outcome from 2'b11 still leaves the entry predicting taken.
- R7: In correlating mode, the same four-taken loop mispredicts exactly once per visit in steady state, at the exit.
- R8: Each update shifts its outcome into history bit 0 and moves bit 0 up to bit 1. The history does not change in a cycle without an update. History is kept in both modes.
- R9: In correlating mode, a branch that strictly alternates taken and not-taken reaches zero mispredictions once trained, because the history selects a separate entry for each phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_1bit_i | input | 1 | 1 selects last-outcome mode, 0 selects correlating mode |
| pred_pc_i | input | 32 | PC of the branch being fetched |
| pred_taken_o | output | 1 | Predicted direction, 1 means taken |
| upd_valid_i | input | 1 | A resolved branch is presented this cycle |
| upd_pc_i | input | 32 | PC of the resolved branch |
| upd_taken_i | input | 1 | Actual direction of the resolved branch |

## Verification
The bench aims at the loop exit. A last-outcome design that keeps history in its index, or that writes the wrong value, gives a misprediction count per visit other than two. A counter that skips saturation or hysteresis gives a count other than one at the exit in correlating mode.

A collision between predict and update on the same entry is driven directly. A design that bypasses the write into the read would return the post-update direction there.

Aliased PCs that differ above bit 5 are checked for sharing an entry. A design that compares tags or folds in high PC bits would predict them independently.

An alternating branch exposes any history that shifts in the wrong order or ends up in the wrong index bits: training never converges and mispredictions persist.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'b01;
  localparam ctr_t CTR_MAX     = 2'b11;
  localparam ctr_t CTR_MIN     = 2'b00;

  // one_bit: entry simply records the last outcome as a saturated value
  function automatic ctr_t ctr_next(input ctr_t cur, input logic taken, input logic one_bit);
    ctr_t nxt;
    if (one_bit)                      nxt = taken ? CTR_MAX : CTR_MIN;
    else if (taken && cur != CTR_MAX) nxt = cur + 2'd1;
    else if (!taken && cur != CTR_MIN) nxt = cur - 2'd1;
    else                              nxt = cur;
    return nxt;
  endfunction
endpackage

// File: rtl/bp_history.sv
module bp_history #(
  parameter int unsigned HIST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (shift_i) hist_q <= {hist_q[HIST_W-2:0], bit_i};
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/bp_index.sv
module bp_index #(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned PC_IDX_W = 4,
  parameter int unsigned HIST_W   = 2,
  localparam int unsigned IDX_W   = PC_IDX_W + HIST_W
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [HIST_W-1:0] hist_i,
  input  logic              one_bit_i,
  output logic [IDX_W-1:0]  idx_o
);
  logic [PC_IDX_W-1:0] pc_part;
  logic                unused_pc;

  assign pc_part   = pc_i[PC_IDX_W+1:2];
  assign unused_pc = ^{pc_i[PC_W-1:PC_IDX_W+2], pc_i[1:0]};

  // last-outcome mode is a plain PC-indexed table
  assign idx_o = one_bit_i ? {{HIST_W{1'b0}}, pc_part} : {hist_i, pc_part};
endmodule

// File: rtl/bp_pattern_table.sv
module bp_pattern_table #(
  parameter int unsigned IDX_W   = 6,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_taken_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i,
  input  logic             one_bit_i
);
  bp_pkg::ctr_t [ENTRIES-1:0] ent_vec;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    bp_pkg::ctr_t ent_q;
    logic         hit;

    assign hit = wr_en_i && (wr_idx_i == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  ent_q <= bp_pkg::CTR_WEAK_NT;
      else if (hit) ent_q <= bp_pkg::ctr_next(ent_q, wr_taken_i, one_bit_i);
    end

    assign ent_vec[e] = ent_q;
  end

  // read straight from flops: same-cycle write is not visible
  assign rd_taken_o = ent_vec[rd_idx_i][1];
endmodule

// File: rtl/branch_corr_pred.sv
module branch_corr_pred #(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned PC_IDX_W = 4,
  parameter int unsigned HIST_W   = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mode_1bit_i,
  input  logic [PC_W-1:0] pred_pc_i,
  output logic            pred_taken_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i
);
  localparam int unsigned IDX_W = PC_IDX_W + HIST_W;

  logic [HIST_W-1:0] hist_q;
  logic [IDX_W-1:0]  rd_idx;
  logic [IDX_W-1:0]  wr_idx;

  bp_history #(.HIST_W(HIST_W)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(upd_valid_i),
    .bit_i  (upd_taken_i),
    .hist_o (hist_q)
  );

  bp_index #(.PC_W(PC_W), .PC_IDX_W(PC_IDX_W), .HIST_W(HIST_W)) u_rd_idx (
    .pc_i     (pred_pc_i),
    .hist_i   (hist_q),
    .one_bit_i(mode_1bit_i),
    .idx_o    (rd_idx)
  );

  bp_index #(.PC_W(PC_W), .PC_IDX_W(PC_IDX_W), .HIST_W(HIST_W)) u_wr_idx (
    .pc_i     (upd_pc_i),
    .hist_i   (hist_q),
    .one_bit_i(mode_1bit_i),
    .idx_o    (wr_idx)
  );

  bp_pattern_table #(.IDX_W(IDX_W)) u_tab (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (rd_idx),
    .rd_taken_o(pred_taken_o),
    .wr_en_i   (upd_valid_i),
    .wr_idx_i  (wr_idx),
    .wr_taken_i(upd_taken_i),
    .one_bit_i (mode_1bit_i)
  );
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned PC_IDX_W = 4,
  parameter int unsigned HIST_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_1bit_i,
  input logic [PC_W-1:0]   pred_pc_i,
  input logic              pred_taken_o,
  input logic              upd_valid_i,
  input logic [PC_W-1:0]   upd_pc_i,
  input logic              upd_taken_i,
  input logic [HIST_W-1:0] hist_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_nt_R1: assert (!pred_taken_o);
  end

  assert_pred_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> (!($stable(pred_pc_i) && $stable(mode_1bit_i)) || $stable(pred_taken_o)));

  assert_last_outcome_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && mode_1bit_i) |=>
      (!(mode_1bit_i && pred_pc_i[PC_IDX_W+1:2] == $past(upd_pc_i[PC_IDX_W+1:2]))
       || pred_taken_o == $past(upd_taken_i)));

  assert_hist_shift_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> (hist_i[0] == $past(upd_taken_i)) &&
                    (hist_i[HIST_W-1:1] == $past(hist_i[HIST_W-2:0])));

  assert_hist_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(hist_i));
endmodule

bind branch_corr_pred bp_checker #(.PC_W(PC_W), .PC_IDX_W(PC_IDX_W), .HIST_W(HIST_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_1bit_i (mode_1bit_i),
  .pred_pc_i   (pred_pc_i),
  .pred_taken_o(pred_taken_o),
  .upd_valid_i (upd_valid_i),
  .upd_pc_i    (upd_pc_i),
  .upd_taken_i (upd_taken_i),
  .hist_i      (hist_q)
);

// File: tb/tb_branch_corr_pred.sv
`timescale 1ns/1ps
module tb_branch_corr_pred;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        mode_1bit_i = 0;
  logic [31:0] pred_pc_i = '0;
  logic        pred_taken_o;
  logic        upd_valid_i = 0;
  logic [31:0] upd_pc_i = '0;
  logic        upd_taken_i = 0;

  int checks = 0;
  int errors = 0;
  logic [1:0] m_tab [64];
  logic [1:0] m_hist;
  logic       last_pred;

  always #2 clk_i = ~clk_i;

  branch_corr_pred dut (.*);

  function automatic int m_idx(input logic [31:0] pc, input logic one_bit);
    return one_bit ? int'(pc[5:2]) : int'({m_hist, pc[5:2]});
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_int(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // called at negedge; compares prediction against the model, then clocks
  task automatic step(input logic m, input logic [31:0] ppc, input logic uv,
                      input logic [31:0] upc, input logic ut, input string tag);
    int i;
    mode_1bit_i = m; pred_pc_i = ppc; upd_valid_i = uv; upd_pc_i = upc; upd_taken_i = ut;
    #1;
    check(pred_taken_o, m_tab[m_idx(ppc, m)][1], tag);
    last_pred = pred_taken_o;
    @(posedge clk_i);
    if (uv) begin
      i = m_idx(upc, m);
      if (m) m_tab[i] = ut ? 2'b11 : 2'b00;
      else if (ut && m_tab[i] != 2'b11) m_tab[i] = m_tab[i] + 2'd1;
      else if (!ut && m_tab[i] != 2'b00) m_tab[i] = m_tab[i] - 2'd1;
      m_hist = {m_hist[0], ut};
    end
    @(negedge clk_i);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int miss;
    logic [31:0] pa, pb;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 64; i++) m_tab[i] = 2'b01;
    m_hist = '0;

    // R1: reset state predicts not-taken everywhere
    for (int k = 0; k < 4; k++) begin
      pred_pc_i = 32'h40 * k + 32'h4 * k;
      #1;
      check(pred_taken_o, 1'b0, "R1 reset prediction");
    end
    @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R6: saturation and hysteresis, P=0x40 (pc[5:2]=0), Q=0x44
    for (int k = 0; k < 4; k++) step(0, 32'h40, 1, 32'h40, 1, "R6 train");
    step(0, 32'h40, 1, 32'h40, 0, "R6 one not-taken");
    step(0, 32'h44, 1, 32'h44, 1, "R6 refill hist");
    step(0, 32'h44, 1, 32'h44, 1, "R6 refill hist");
    step(0, 32'h40, 0, 32'h0, 0, "R6 probe");
    check(last_pred, 1'b1, "R6 strong counter survives one not-taken");
    step(0, 32'h40, 1, 32'h40, 0, "R2 collision pre-update");
    check(last_pred, 1'b1, "R2 same-cycle update not visible");
    step(0, 32'h44, 1, 32'h44, 1, "R6 refill hist");
    step(0, 32'h44, 1, 32'h44, 1, "R6 refill hist");
    step(0, 32'h40, 0, 32'h0, 0, "R6 probe");
    check(last_pred, 1'b0, "R6 second not-taken flips counter");

    // R3 / R4: aliasing in last-outcome mode, idx 2
    step(1, 32'h1008, 1, 32'h1008, 1, "R4 train");
    step(1, 32'h2008, 0, 32'h0, 0, "R3 alias probe");
    check(last_pred, 1'b1, "R3 aliased PC shares entry");
    step(1, 32'h2008, 1, 32'h2008, 0, "R4 train alias");
    step(1, 32'h1008, 0, 32'h0, 0, "R4 probe");
    check(last_pred, 1'b0, "R4 last outcome predicted");

    // R5: last-outcome loop, 4 taken then exit
    for (int v = 0; v < 4; v++) begin
      miss = 0;
      for (int it = 0; it < 5; it++) begin
        step(1, 32'h80, 1, 32'h80, it < 4, "R5 loop");
        if (last_pred != (it < 4)) miss++;
      end
      if (v > 0) check_int(miss, 2, "R5 mispredicts per visit");
    end

    // R7: correlating loop, pc idx 5
    for (int v = 0; v < 7; v++) begin
      miss = 0;
      for (int it = 0; it < 5; it++) begin
        step(0, 32'h94, 1, 32'h94, it < 4, "R7 loop");
        if (last_pred != (it < 4)) miss++;
      end
      if (v > 3) check_int(miss, 1, "R7 mispredicts per visit");
    end

    // R9: alternating branch learned via history, pc idx 9
    for (int k = 0; k < 16; k++) step(0, 32'hA4, 1, 32'hA4, k[0], "R9 warmup");
    miss = 0;
    for (int k = 0; k < 20; k++) begin
      step(0, 32'hA4, 1, 32'hA4, k[0], "R9 alternate");
      if (last_pred != k[0]) miss++;
    end
    check_int(miss, 0, "R9 alternating mispredicts");

    // R2/R3/R6/R8: random traffic against the model
    for (int k = 0; k < 2000; k++) begin
      pa = $urandom; pb = ($urandom % 3 == 0) ? pa : $urandom;
      step(($urandom % 4) == 0, pa, ($urandom % 4) != 0, pb, $urandom % 2, "R3 R6 R8 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule